// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the word addresses for one DMA channel that walks a rectangular region of memory. The region is a set of lines. Each line has an active length in words and starts a fixed stride after the line before it. Software programs the start word address, the line length, the line count, the stride, a direction bit, a burst bit and a pair of loop enables through a small indexed register port. Software then writes the start bit. The block presents a request together with the current word address. It advances by exactly one word on every cycle in which the data mover acknowledges that request.

In normal mode the channel visits line 0 through line `ylen`. After the last word of the last line it goes idle and latches a done interrupt. A line length of zero selects circular loop mode instead. In loop mode the address runs continuously over `stride × (ylen+1)` words and returns to the start address at the end. The block raises one interrupt at the end of the first half of that area and another at the end of the second half, on every pass. Loop operation also needs both loop enable bits. With either bit clear, the channel is paused: the address holds and resumes from the same place. The current word address can be read back at any time, so software can compute the residue.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `xfer_req` and `irq` are low. Every readable register, including the status (index 6) and the current position (index 7), reads zero.
- R2: Registers read back what was written, masked to their widths. Index 0 is the start word address. Index 1 is the line length. Index 2 is the line count minus one. Index 3 is the stride. Index 4 is control: burst at bit 4, direction at bit 5, and bit 0 is a start bit that always reads zero. Index 5 holds the loop enables at bits 0 and 16.
- R3: A write to index 4 with bit 0 set, while the channel is idle, starts it. From the next cycle `xfer_req` is high and `xfer_addr` equals the start address. A start written while the channel is busy is ignored. `xfer_dir` and `xfer_burst` follow control bits 5 and 4 (direction 1 = memory to device).
- R4: In normal mode (line length nonzero) the addresses run `base + y*stride + x`, for x from 0 to length−1 and y from 0 to `ylen`. The address advances once per cycle with `xfer_req` and `xfer_ack` both high, and never without `xfer_ack`.
- R5: The beat that completes the last word of line `ylen` drops `xfer_req` from the next cycle. The same beat sets status bit 0 (done) and raises `irq`, once per transfer.
- R6: Status bits are cleared by writing 1 to them at index 6. Writing 0 leaves them set. A new event in the same cycle wins over a clear. `irq` is high whenever any status bit is set.
- R7: In loop mode (line length zero) the address advances from the start address through `stride*(ylen+1)` words and then returns to the start address, without stopping.
- R8: In loop mode, status bit 1 is set by the beat at offset `stride*((ylen+1)/2) − 1`. Status bit 2 is set by the beat at offset `stride*(ylen+1) − 1`. Both happen on every pass, and loop mode never sets the done bit.
- R9: In loop mode, if either loop enable bit (index 5, bit 0 or bit 16) is clear, `xfer_req` is low and the address holds. Setting both bits again resumes from the held address.
- R10: Writing 1 to bit 0 of index 7 aborts the channel. `xfer_req` falls on the next cycle and no done interrupt is raised.
- R11: Reading index 7 returns the current word address, equal to `xfer_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register write index |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_idx | input | 3 | Register read index |
| reg_rd_data | output | 32 | Register read data (combinational) |
| xfer_req | output | 1 | Word request to the data mover |
| xfer_ack | input | 1 | Word accepted; address advances |
| xfer_addr | output | ADDR_W | Current word address |
| xfer_dir | output | 1 | 1 = memory to device, 0 = device to memory |
| xfer_burst | output | 1 | Burst mode select |
| irq | output | 1 | Any status bit pending |

## Verification
The bench builds the block with a 16-bit address and 6-bit length fields. At these widths the start, stride and line values used land at easily told addresses, and the register masks on readback can be seen. A three-by-three walk with stride 5 shows the jump between lines. A four-line loop area with stride 2 gives an eight-word region with a four-word half, so two full passes, both half interrupts and the wrap all appear within a few dozen cycles. The same widths keep the pause, abort and restart cases short.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  localparam int REG_DW = 32;
  localparam int IDX_W  = 3;

  // register indices
  localparam logic [IDX_W-1:0] RG_BASE     = 3'd0;
  localparam logic [IDX_W-1:0] RG_LINE_LEN = 3'd1;
  localparam logic [IDX_W-1:0] RG_LINE_CNT = 3'd2;
  localparam logic [IDX_W-1:0] RG_STRIDE   = 3'd3;
  localparam logic [IDX_W-1:0] RG_CTRL     = 3'd4;
  localparam logic [IDX_W-1:0] RG_LOOP     = 3'd5;
  localparam logic [IDX_W-1:0] RG_STATUS   = 3'd6;
  localparam logic [IDX_W-1:0] RG_POS      = 3'd7;   // read: position, write: abort

  // control bits
  localparam int CTRL_GO_BIT    = 0;
  localparam int CTRL_BURST_BIT = 4;
  localparam int CTRL_DIR_BIT   = 5;

  // loop enable pair
  localparam int LOOP_EN_LO = 0;
  localparam int LOOP_EN_HI = 16;

  // status bits
  localparam int ST_DONE   = 0;
  localparam int ST_HALF_A = 1;
  localparam int ST_HALF_B = 2;
  localparam int ST_NUM    = 3;

endpackage

// File: rtl/dma2d_regs.sv
module dma2d_regs
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [REG_DW-1:0]     wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [REG_DW-1:0]     rd_data,
  input  logic [ST_NUM-1:0]     status,
  input  logic [ADDR_W-1:0]     cur_addr,
  output logic [ADDR_W-1:0]     base_q,
  output logic [LEN_W-1:0]      xlen_q,
  output logic [LEN_W-1:0]      ylen_q,
  output logic [LEN_W-1:0]      stride_q,
  output logic                  burst_q,
  output logic                  dir_q,
  output logic                  loop_ok,
  output logic                  start_pulse,
  output logic                  abort_pulse,
  output logic [ST_NUM-1:0]     clr_mask
);

  logic loop_lo_q, loop_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      xlen_q    <= '0;
      ylen_q    <= '0;
      stride_q  <= '0;
      burst_q   <= 1'b0;
      dir_q     <= 1'b0;
      loop_lo_q <= 1'b0;
      loop_hi_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_idx)
        RG_BASE:     base_q   <= wr_data[ADDR_W-1:0];
        RG_LINE_LEN: xlen_q   <= wr_data[LEN_W-1:0];
        RG_LINE_CNT: ylen_q   <= wr_data[LEN_W-1:0];
        RG_STRIDE:   stride_q <= wr_data[LEN_W-1:0];
        RG_CTRL: begin
          burst_q <= wr_data[CTRL_BURST_BIT];
          dir_q   <= wr_data[CTRL_DIR_BIT];
        end
        RG_LOOP: begin
          loop_lo_q <= wr_data[LOOP_EN_LO];
          loop_hi_q <= wr_data[LOOP_EN_HI];
        end
        default: ;
      endcase
    end
  end

  // both enables are needed for circular operation
  assign loop_ok     = loop_lo_q & loop_hi_q;
  assign start_pulse = wr_en && (wr_idx == RG_CTRL) && wr_data[CTRL_GO_BIT];
  assign abort_pulse = wr_en && (wr_idx == RG_POS) && wr_data[0];
  assign clr_mask    = (wr_en && (wr_idx == RG_STATUS)) ? wr_data[ST_NUM-1:0] : '0;

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      RG_BASE:     rd_data[ADDR_W-1:0] = base_q;
      RG_LINE_LEN: rd_data[LEN_W-1:0]  = xlen_q;
      RG_LINE_CNT: rd_data[LEN_W-1:0]  = ylen_q;
      RG_STRIDE:   rd_data[LEN_W-1:0]  = stride_q;
      RG_CTRL: begin
        rd_data[CTRL_BURST_BIT] = burst_q;
        rd_data[CTRL_DIR_BIT]   = dir_q;
      end
      RG_LOOP: begin
        rd_data[LOOP_EN_LO] = loop_lo_q;
        rd_data[LOOP_EN_HI] = loop_hi_q;
      end
      RG_STATUS:   rd_data[ST_NUM-1:0] = status;
      RG_POS:      rd_data[ADDR_W-1:0] = cur_addr;
      default:     rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  xlen,
  input  logic [LEN_W-1:0]  ylen,
  input  logic [LEN_W-1:0]  stride,
  input  logic              loop_ok,
  input  logic              ack,
  output logic              busy,
  output logic              req,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              loop_mode,
  output logic              beat,
  output logic              line_end,
  output logic              done_evt,
  output logic              half_a_evt,
  output logic              half_b_evt
);

  localparam int OFF_W = 2 * LEN_W + 1;

  // words in the circular area: stride * lines
  function automatic logic [OFF_W-1:0] region_words(input logic [LEN_W-1:0] st,
                                                    input logic [LEN_W-1:0] yl);
    return OFF_W'(st) * (OFF_W'(yl) + OFF_W'(1));
  endfunction

  // words in the first half: stride * floor(lines/2)
  function automatic logic [OFF_W-1:0] half_words(input logic [LEN_W-1:0] st,
                                                  input logic [LEN_W-1:0] yl);
    return OFF_W'(st) * ((OFF_W'(yl) + OFF_W'(1)) >> 1);
  endfunction

  logic [ADDR_W-1:0] cfg_base;
  logic [ADDR_W-1:0] line_base;
  logic [LEN_W-1:0]  cfg_xlen;
  logic [LEN_W-1:0]  cfg_ylen;
  logic [ADDR_W-1:0] cfg_step;
  logic [LEN_W-1:0]  x_cnt;
  logic [LEN_W-1:0]  y_cnt;
  logic [OFF_W-1:0]  off_cnt;
  logic [OFF_W-1:0]  region_q;
  logic [OFF_W-1:0]  half_q;
  logic              loop_mode_q;
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;

  logic [OFF_W-1:0]  off_nxt;
  logic              last_line;
  logic              region_end;

  assign busy      = busy_q;
  assign cur_addr  = addr_q;
  assign loop_mode = loop_mode_q;

  assign req  = busy_q && (!loop_mode_q || loop_ok);
  assign beat = req && ack;

  assign off_nxt    = off_cnt + OFF_W'(1);
  assign line_end   = !loop_mode_q && (x_cnt == cfg_xlen - LEN_W'(1));
  assign last_line  = (y_cnt == cfg_ylen);
  assign region_end = loop_mode_q && (off_nxt == region_q);

  assign done_evt   = beat && line_end && last_line;
  assign half_a_evt = beat && loop_mode_q && (half_q != '0) && (off_nxt == half_q);
  assign half_b_evt = beat && region_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      loop_mode_q <= 1'b0;
      addr_q      <= '0;
      cfg_base    <= '0;
      line_base   <= '0;
      cfg_xlen    <= '0;
      cfg_ylen    <= '0;
      cfg_step    <= '0;
      x_cnt       <= '0;
      y_cnt       <= '0;
      off_cnt     <= '0;
      region_q    <= '0;
      half_q      <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (start && !busy_q) begin
      busy_q      <= 1'b1;
      loop_mode_q <= (xlen == '0);
      cfg_base    <= base;
      line_base   <= base;
      addr_q      <= base;
      cfg_xlen    <= xlen;
      cfg_ylen    <= ylen;
      cfg_step    <= ADDR_W'(stride);
      x_cnt       <= '0;
      y_cnt       <= '0;
      off_cnt     <= '0;
      region_q    <= region_words(stride, ylen);
      half_q      <= half_words(stride, ylen);
    end else if (beat) begin
      if (loop_mode_q) begin
        if (region_end) begin
          off_cnt <= '0;
          addr_q  <= cfg_base;
        end else begin
          off_cnt <= off_nxt;
          addr_q  <= addr_q + ADDR_W'(1);
        end
      end else if (line_end) begin
        if (last_line) begin
          busy_q <= 1'b0;
        end else begin
          y_cnt     <= y_cnt + LEN_W'(1);
          x_cnt     <= '0;
          line_base <= line_base + cfg_step;
          addr_q    <= line_base + cfg_step;
        end
      end else begin
        x_cnt  <= x_cnt + LEN_W'(1);
        addr_q <= addr_q + ADDR_W'(1);
      end
    end
  end

endmodule

// File: rtl/dma2d_irq.sv
module dma2d_irq #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] status,
  output logic               irq
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic pend_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (set_vec[i]) pend_q <= 1'b1;   // a new event beats a clear
      else if (clr_vec[i]) pend_q <= 1'b0;
    end
    assign status[i] = pend_q;
  end

  assign irq = |status;

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_idx,
  input  logic [31:0]       reg_wr_data,
  input  logic [2:0]        reg_rd_idx,
  output logic [31:0]       reg_rd_data,
  output logic              xfer_req,
  input  logic              xfer_ack,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              xfer_dir,
  output logic              xfer_burst,
  output logic              irq
);

  logic [ADDR_W-1:0] reg_base;
  logic [LEN_W-1:0]  reg_xlen;
  logic [LEN_W-1:0]  reg_ylen;
  logic [LEN_W-1:0]  reg_stride;
  logic              loop_ok;
  logic              start_pulse;
  logic              abort_pulse;
  logic [ST_NUM-1:0] clr_mask;
  logic [ST_NUM-1:0] irq_status;
  logic [ST_NUM-1:0] evt_vec;

  logic chan_busy;
  logic loop_mode;
  logic beat;
  logic line_end;
  logic done_evt;
  logic half_a_evt;
  logic half_b_evt;

  dma2d_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .wr_idx     (reg_wr_idx),
    .wr_data    (reg_wr_data),
    .rd_idx     (reg_rd_idx),
    .rd_data    (reg_rd_data),
    .status     (irq_status),
    .cur_addr   (xfer_addr),
    .base_q     (reg_base),
    .xlen_q     (reg_xlen),
    .ylen_q     (reg_ylen),
    .stride_q   (reg_stride),
    .burst_q    (xfer_burst),
    .dir_q      (xfer_dir),
    .loop_ok    (loop_ok),
    .start_pulse(start_pulse),
    .abort_pulse(abort_pulse),
    .clr_mask   (clr_mask)
  );

  dma2d_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_pulse),
    .abort     (abort_pulse),
    .base      (reg_base),
    .xlen      (reg_xlen),
    .ylen      (reg_ylen),
    .stride    (reg_stride),
    .loop_ok   (loop_ok),
    .ack       (xfer_ack),
    .busy      (chan_busy),
    .req       (xfer_req),
    .cur_addr  (xfer_addr),
    .loop_mode (loop_mode),
    .beat      (beat),
    .line_end  (line_end),
    .done_evt  (done_evt),
    .half_a_evt(half_a_evt),
    .half_b_evt(half_b_evt)
  );

  always_comb begin
    evt_vec            = '0;
    evt_vec[ST_DONE]   = done_evt;
    evt_vec[ST_HALF_A] = half_a_evt;
    evt_vec[ST_HALF_B] = half_b_evt;
  end

  dma2d_irq #(.NUM_SRC(ST_NUM)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(evt_vec),
    .clr_vec(clr_mask),
    .status (irq_status),
    .irq    (irq)
  );

endmodule

// File: rtl/dma2d_checker.sv
module dma2d_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_req,
  input logic              xfer_ack,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic              irq,
  input logic [ADDR_W-1:0] reg_base,
  input logic              loop_ok,
  input logic              start_pulse,
  input logic              abort_pulse,
  input logic              clr_done,
  input logic              st_done,
  input logic              chan_busy,
  input logic              loop_mode,
  input logic              beat,
  input logic              line_end,
  input logic              done_evt
);

  AST_START_LOADS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !chan_busy && !abort_pulse) |=> (chan_busy && xfer_addr == $past(reg_base))); // R3

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !loop_mode && !line_end && !abort_pulse) |=> (xfer_addr == $past(xfer_addr) + ADDR_W'(1))); // R4

  AST_HOLD_WITHOUT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_busy && !(xfer_req && xfer_ack) && !start_pulse && !abort_pulse) |=> $stable(xfer_addr)); // R9

  AST_DONE_STOPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !xfer_req); // R5

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (irq && st_done)); // R5

  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !done_evt) |=> !st_done); // R6

  AST_PAUSE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_busy && loop_mode && !loop_ok) |-> !xfer_req); // R9

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !xfer_req); // R10

endmodule

bind dma2d_addr_gen dma2d_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_req   (xfer_req),
  .xfer_ack   (xfer_ack),
  .xfer_addr  (xfer_addr),
  .irq        (irq),
  .reg_base   (reg_base),
  .loop_ok    (loop_ok),
  .start_pulse(start_pulse),
  .abort_pulse(abort_pulse),
  .clr_done   (clr_mask[0]),
  .st_done    (irq_status[0]),
  .chan_busy  (chan_busy),
  .loop_mode  (loop_mode),
  .beat       (beat),
  .line_end   (line_end),
  .done_evt   (done_evt)
);

// File: tb/tb_dma2d_addr_gen.sv
`timescale 1ns/1ps
module tb_dma2d_addr_gen;

  localparam int AW = 16;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic [2:0]    rd_idx = '0;
  logic [31:0]   rd_data;
  logic          req;
  logic          ack = 1'b0;
  logic [AW-1:0] addr;
  logic          dir;
  logic          burst;
  logic          irq;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;   // 125 MHz

  dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(wr_en), .reg_wr_idx(wr_idx), .reg_wr_data(wr_data),
    .reg_rd_idx(rd_idx), .reg_rd_data(rd_data),
    .xfer_req(req), .xfer_ack(ack), .xfer_addr(addr),
    .xfer_dir(dir), .xfer_burst(burst), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] val);
    rd_idx = idx;
    #1;
    val = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 req after reset", 32'(req), 0);
    check("R1 irq after reset", 32'(irq), 0);
    rd(6, v); check("R1 status after reset", v, 0);
    rd(7, v); check("R1 position after reset", v, 0);
    rd(0, v); check("R1 base after reset", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(0, 32'hABCD_1234); rd(0, v); check("R2 base readback", v, 32'h1234);
    wr(1, 32'hFFFF_FFC5); rd(1, v); check("R2 length readback", v, 32'h05);
    wr(3, 32'h0000_0127); rd(3, v); check("R2 stride readback", v, 32'h27);
    wr(4, 32'h0000_0030); rd(4, v); check("R2 control readback", v, 32'h30);
    check("R3 dir follows control", 32'(dir), 1);
    check("R3 burst follows control", 32'(burst), 1);
    wr(5, 32'hFFFF_FFFF); rd(5, v); check("R2 loop readback", v, 32'h0001_0001);
    wr(5, 0);
    check("R3 no start without go bit", 32'(req), 0);
  endtask

  task automatic t_normal();
    logic [31:0] v;
    wr(0, 32'h100); wr(1, 3); wr(2, 2); wr(3, 5);
    wr(4, 32'h21);
    check("R3 req after start", 32'(req), 1);
    check("R3 dir set", 32'(dir), 1);
    check("R3 burst clear", 32'(burst), 0);
    repeat (3) @(negedge clk);
    check("R4 no step without ack", 32'(addr), 32'h100);
    for (int y = 0; y <= 2; y++) begin
      for (int x = 0; x < 3; x++) begin
        if (y == 1 && x == 0) begin
          ack = 1'b0;
          wr(0, 32'h500); wr(4, 32'h21);   // start while busy: ignored
          check("R3 start while busy ignored", 32'(addr), 32'h105);
          rd(7, v); check("R11 position readback", v, 32'h105);
        end
        check("R4 walk address", 32'(addr), 32'(32'h100 + y*5 + x));
        ack = 1'b1;
        @(negedge clk);
      end
    end
    ack = 1'b1;
    check("R5 req drops after last word", 32'(req), 0);
    check("R5 irq raised", 32'(irq), 1);
    repeat (3) @(negedge clk);
    ack = 1'b0;
    rd(6, v); check("R5 single done status", v, 1);
    check("R5 address stays at last word", 32'(addr), 32'h10C);
    wr(6, 0); rd(6, v); check("R6 write 0 keeps status", v, 1);
    wr(6, 1); rd(6, v); check("R6 write 1 clears status", v, 0);
    check("R6 irq low after clear", 32'(irq), 0);
  endtask

  task automatic t_loop();
    logic [31:0] v;
    wr(0, 32'h40); wr(1, 0); wr(2, 3); wr(3, 2);
    wr(5, 32'h0001_0001);
    wr(4, 32'h01);
    for (int i = 0; i < 16; i++) begin
      check("R7 circular address", 32'(addr), 32'(32'h40 + (i % 8)));
      ack = 1'b1;
      @(negedge clk);
      if ((i % 8) == 3) begin
        ack = 1'b0;
        rd(6, v); check("R8 first half interrupt", v, 2);
        wr(6, 2);
      end else if ((i % 8) == 7) begin
        ack = 1'b0;
        rd(6, v); check("R8 second half interrupt, no done", v, 4);
        wr(6, 4);
      end
    end
    check("R7 wrapped to base", 32'(addr), 32'h40);
    ack = 1'b1;
    repeat (2) @(negedge clk);
    ack = 1'b0;
    check("R7 advanced after wrap", 32'(addr), 32'h42);
    wr(5, 32'h0000_0001);
    ack = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 paused req low", 32'(req), 0);
    check("R9 paused address held", 32'(addr), 32'h42);
    wr(5, 32'h0001_0000);
    check("R9 one enable still paused", 32'(req), 0);
    wr(5, 32'h0001_0001);
    check("R9 resume req", 32'(req), 1);
    check("R9 resume address", 32'(addr), 32'h42);
    @(negedge clk);
    ack = 1'b0;
    check("R9 resumes stepping", 32'(addr), 32'h43);
    wr(7, 1);
    check("R10 loop abort", 32'(req), 0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(6, 7);
    wr(0, 32'h200); wr(1, 4); wr(2, 0); wr(3, 4);
    wr(4, 32'h01);
    ack = 1'b1;
    repeat (2) @(negedge clk);
    ack = 1'b0;
    check("R4 partial walk", 32'(addr), 32'h202);
    wr(7, 1);
    check("R10 req low after abort", 32'(req), 0);
    ack = 1'b1;
    repeat (5) @(negedge clk);
    ack = 1'b0;
    check("R10 no irq after abort", 32'(irq), 0);
    rd(6, v); check("R10 no done after abort", v, 0);
    wr(4, 32'h01);
    check("R3 restart after abort", 32'(addr), 32'h200);
    check("R3 restart req", 32'(req), 1);
    ack = 1'b1;
    repeat (4) @(negedge clk);
    ack = 1'b0;
    check("R5 single-line done", 32'(irq), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_normal();
    t_loop();
    t_abort();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule